// File: doc/BRIEF.md
# Debug Address Comparator Trigger Unit

This block observes every CPU bus cycle and compares its address against three programmed comparators. Comparators A and B produce the trigger event. Comparator C produces a CPU break request. A match can be qualified by bus direction. The trigger event is chosen from the A and B results by a mode field.

A trigger can be force-type or tagged. A force-type trigger fires on the bus cycle that matches. A tagged trigger marks an opcode fetch and fires only when that opcode reaches execution. Tags travel through a small first-in first-out queue that follows the instruction pipeline. A pipeline flush empties the queue. Breakpoint C is always tagged. When its tag and an A/B tag sit on the same instruction, breakpoint C takes precedence.

A separate arm input enables the trigger. After the trigger fires once, the unit must be armed again.

Top module: `dbg_trig_unit`

## Requirements
- R1: With its direction enable at 0, a comparator matches on address alone, for both reads (`bus_rd`=1) and writes (`bus_rd`=0).
- R2: With direction enable 1 and direction select 0, a comparator matches only on write cycles (`bus_rd`=0).
- R3: With direction enable 1 and direction select 1, a comparator matches only on read cycles (`bus_rd`=1).
- R4: When `page_sel` equals 2'b01, a match also needs `bus_page` equal to the comparator's page byte. For any other `page_sel` value the page byte is ignored.
- R5: With `tag_sel`=0, an armed unit raises `trig` for exactly one cycle, in the cycle after the qualifying bus cycle. `trig` never rises while the unit is unarmed. Firing disarms the unit until `arm` is pulsed again.
- R6: With `tag_sel`=1, the direction bits of A and B are ignored. A fetch (`bus_fetch`=1) that matches only tags its opcode. `trig` rises in the cycle after the `exec_valid` cycle that retires that tag. Tags retire in fetch order.
- R7: In `trig_mode` values 2 and 3, the direction enable and select of A qualify comparator B as well, and B's own direction bits are ignored.
- R8: The `trig_mode` encodings are: 0 = A or B; 1 = A only; 2 = B after an earlier A since arming; 3 = A without B in the same event.
- R9: `brk_req` pulses in the cycle after the `exec_valid` cycle that retires a fetch matching C while `brk_en`=1. When such a tag carries an A/B tag as well, the A/B trigger is suppressed and the unit stays armed.
- R10: `pipe_flush` discards every queued tag. A discarded tag never produces `trig` or `brk_req`.
- R11: A synchronous active-high `rst` clears the match flags, the outputs, the queue and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | AW | Bus address |
| bus_page | input | PW | Upper address byte of the cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | The cycle is an opcode fetch |
| exec_valid | input | 1 | The oldest fetched opcode starts execution |
| pipe_flush | input | 1 | Pipeline flush, discards tags |
| cmp_addr_a | input | AW | Comparator A address |
| cmp_addr_b | input | AW | Comparator B address |
| cmp_addr_c | input | AW | Comparator C address |
| cmp_page_a | input | PW | Comparator A page byte |
| cmp_page_b | input | PW | Comparator B page byte |
| cmp_page_c | input | PW | Comparator C page byte |
| page_sel | input | 2 | 2'b01 enables page comparison |
| dir_en_a | input | 1 | Direction qualification enable, A |
| dir_rd_a | input | 1 | Direction select, A (1 = reads) |
| dir_en_b | input | 1 | Direction qualification enable, B |
| dir_rd_b | input | 1 | Direction select, B (1 = reads) |
| tag_sel | input | 1 | 0 = force-type, 1 = tagged trigger |
| trig_mode | input | 2 | A/B combination mode |
| brk_en | input | 1 | Enables breakpoint C |
| arm | input | 1 | Arms the trigger |
| match_a | output | 1 | Registered qualified match, A |
| match_b | output | 1 | Registered qualified match, B |
| match_c | output | 1 | Registered address match, C |
| trig | output | 1 | Trigger pulse |
| brk_req | output | 1 | CPU break request pulse |

## Verification
The assertions assume that configuration inputs stay steady while tags are in flight. They also assume the pipeline never holds more unexecuted fetches than the tag queue depth. One assertion flags a push into a full queue with no pop in the same cycle.

The stimulus respects these limits. Configuration changes only while no bus traffic is pending or straight after a reset. At most three fetches are outstanding before execution, against a queue of four. The direction and page rules are swept over every combination of enables, selects, modes, direction and address equality.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    MODE_ANY      = 2'd0,
    MODE_A_ONLY   = 2'd1,
    MODE_A_THEN_B = 2'd2,
    MODE_A_NOT_B  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } tag_t;

  localparam int NCMP = 3;
  localparam int CMP_A = 0;
  localparam int CMP_B = 1;
  localparam int CMP_C = 2;
  localparam logic [1:0] PAGE_CMP_ON = 2'b01;

  // Event selection shared by the force path and the tagged path.
  function automatic logic ab_event(trig_mode_e mode, logic a, logic b, logic seq);
    case (mode)
      MODE_ANY:      return a | b;
      MODE_A_ONLY:   return a;
      MODE_A_THEN_B: return b & seq;
      default:       return a & ~b;
    endcase
  endfunction

endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [PW-1:0] bus_page,
  input  logic          bus_rd,
  input  logic [AW-1:0] ref_addr,
  input  logic [PW-1:0] ref_page,
  input  logic          page_en,
  input  logic          qual_en,
  input  logic          qual_rd,
  output logic          hit
);

  logic addr_eq;
  logic page_ok;
  logic dir_ok;

  always_comb begin
    addr_eq = (bus_addr == ref_addr);
    page_ok = !page_en || (bus_page == ref_page);
    dir_ok  = !qual_en || (bus_rd == qual_rd);
    hit     = bus_valid && addr_eq && page_ok && dir_ok;
  end

endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue
  import dbg_trig_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  tag_t          push_tag,
  input  logic          pop_req,
  output logic          pop,
  output tag_t          head,
  output logic [CW-1:0] count
);

  tag_t            mem [DEPTH];
  logic [PTRW-1:0] wr_ptr;
  logic [PTRW-1:0] rd_ptr;
  logic            do_push;

  function automatic logic [PTRW-1:0] ptr_inc(logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop     = pop_req && (count != '0) && !flush;
    do_push = push && !flush;
    head    = mem[rd_ptr];
  end

  // Storage without reset so it maps onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)     rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(do_push) - CW'(pop);
    end
  end

endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tag_sel,
  input  logic [1:0] mode,
  input  logic       brk_en,
  input  logic       arm,
  input  logic       live_a,
  input  logic       live_b,
  input  logic       pop,
  input  tag_t       head,
  output logic       trig,
  output logic       brk_req,
  output logic       armed
);

  trig_mode_e mode_e;
  logic       seq;
  logic       c_wins;
  logic       src_a;
  logic       src_b;
  logic       fire;
  logic       seq_n;
  logic       armed_n;
  logic       brk_n;

  always_comb begin
    mode_e  = trig_mode_e'(mode);
    c_wins  = pop && head.c && brk_en;
    src_a   = tag_sel ? (pop && head.a && !c_wins) : live_a;
    src_b   = tag_sel ? (pop && head.b && !c_wins) : live_b;
    fire    = armed && ab_event(mode_e, src_a, src_b, seq);
    seq_n   = fire ? 1'b0 : (seq || (armed && src_a && mode_e == MODE_A_THEN_B));
    armed_n = fire ? 1'b0 : (arm ? 1'b1 : armed);
    brk_n   = c_wins;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig    <= 1'b0;
      brk_req <= 1'b0;
      armed   <= 1'b0;
      seq     <= 1'b0;
    end else begin
      trig    <= fire;
      brk_req <= brk_n;
      armed   <= armed_n;
      seq     <= seq_n;
    end
  end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PW     = 8,
  parameter int QDEPTH = 4,
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [PW-1:0] bus_page,
  input  logic          bus_rd,
  input  logic          bus_fetch,
  input  logic          exec_valid,
  input  logic          pipe_flush,
  input  logic [AW-1:0] cmp_addr_a,
  input  logic [AW-1:0] cmp_addr_b,
  input  logic [AW-1:0] cmp_addr_c,
  input  logic [PW-1:0] cmp_page_a,
  input  logic [PW-1:0] cmp_page_b,
  input  logic [PW-1:0] cmp_page_c,
  input  logic [1:0]    page_sel,
  input  logic          dir_en_a,
  input  logic          dir_rd_a,
  input  logic          dir_en_b,
  input  logic          dir_rd_b,
  input  logic          tag_sel,
  input  logic [1:0]    trig_mode,
  input  logic          brk_en,
  input  logic          arm,
  output logic          match_a,
  output logic          match_b,
  output logic          match_c,
  output logic          trig,
  output logic          brk_req
);

  logic [AW-1:0]  ref_addr [NCMP];
  logic [PW-1:0]  ref_page [NCMP];
  logic [NCMP-1:0] q_en;
  logic [NCMP-1:0] q_rd;
  logic [NCMP-1:0] hit;
  logic            full_mode;
  logic            page_on;
  logic            q_push;
  logic            q_pop;
  tag_t            q_head;
  tag_t            q_in;
  logic [QCW-1:0]  q_count;
  logic            armed;

  // Direction qualification: off when tagged, A's bits drive B in combined modes.
  always_comb begin
    full_mode     = trig_mode[1];
    page_on       = (page_sel == PAGE_CMP_ON);
    ref_addr[CMP_A] = cmp_addr_a;
    ref_addr[CMP_B] = cmp_addr_b;
    ref_addr[CMP_C] = cmp_addr_c;
    ref_page[CMP_A] = cmp_page_a;
    ref_page[CMP_B] = cmp_page_b;
    ref_page[CMP_C] = cmp_page_c;
    q_en[CMP_A]   = dir_en_a && !tag_sel;
    q_rd[CMP_A]   = dir_rd_a;
    q_en[CMP_B]   = (full_mode ? dir_en_a : dir_en_b) && !tag_sel;
    q_rd[CMP_B]   = full_mode ? dir_rd_a : dir_rd_b;
    q_en[CMP_C]   = 1'b0;
    q_rd[CMP_C]   = 1'b0;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    dbg_addr_cmp #(.AW(AW), .PW(PW)) u_cmp (
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_page  (bus_page),
      .bus_rd    (bus_rd),
      .ref_addr  (ref_addr[g]),
      .ref_page  (ref_page[g]),
      .page_en   (page_on),
      .qual_en   (q_en[g]),
      .qual_rd   (q_rd[g]),
      .hit       (hit[g])
    );
  end

  always_comb begin
    q_push = bus_valid && bus_fetch;
    q_in.a = hit[CMP_A];
    q_in.b = hit[CMP_B];
    q_in.c = hit[CMP_C];
  end

  dbg_tag_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (pipe_flush),
    .push     (q_push),
    .push_tag (q_in),
    .pop_req  (exec_valid),
    .pop      (q_pop),
    .head     (q_head),
    .count    (q_count)
  );

  dbg_trig_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .tag_sel (tag_sel),
    .mode    (trig_mode),
    .brk_en  (brk_en),
    .arm     (arm),
    .live_a  (hit[CMP_A]),
    .live_b  (hit[CMP_B]),
    .pop     (q_pop),
    .head    (q_head),
    .trig    (trig),
    .brk_req (brk_req),
    .armed   (armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_a <= 1'b0;
      match_b <= 1'b0;
      match_c <= 1'b0;
    end else begin
      match_a <= hit[CMP_A];
      match_b <= hit[CMP_B];
      match_c <= hit[CMP_C];
    end
  end

endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk #(
  parameter int QDEPTH = 4,
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_rd,
  input logic           exec_valid,
  input logic           pipe_flush,
  input logic           dir_en_a,
  input logic           dir_rd_a,
  input logic           tag_sel,
  input logic           match_a,
  input logic           trig,
  input logic           brk_req,
  input logic           armed,
  input logic           q_push,
  input logic           q_pop,
  input logic [QCW-1:0] q_count
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  a_r5_needs_arm: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(armed));

  a_r5_disarms: assert property (@(posedge clk) disable iff (rst)
    trig |-> !armed);

  a_r6_fires_on_exec: assert property (@(posedge clk) disable iff (rst)
    (trig && $past(tag_sel)) |-> $past(exec_valid));

  a_r9_c_wins: assert property (@(posedge clk) disable iff (rst)
    (brk_req && $past(tag_sel)) |-> !trig);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    pipe_flush |=> (q_count == '0));

  a_r10_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (q_push && !q_pop && !pipe_flush) |-> (q_count < QCW'(QDEPTH)));

  a_r2_write_only: assert property (@(posedge clk) disable iff (rst)
    (match_a && $past(dir_en_a && !dir_rd_a && !tag_sel)) |-> !$past(bus_rd));

  a_r3_read_only: assert property (@(posedge clk) disable iff (rst)
    (match_a && $past(dir_en_a && dir_rd_a && !tag_sel)) |-> $past(bus_rd));

endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .exec_valid (exec_valid),
  .pipe_flush (pipe_flush),
  .dir_en_a   (dir_en_a),
  .dir_rd_a   (dir_rd_a),
  .tag_sel    (tag_sel),
  .match_a    (match_a),
  .trig       (trig),
  .brk_req    (brk_req),
  .armed      (armed),
  .q_push     (q_push),
  .q_pop      (q_pop),
  .q_count    (q_count)
);

// File: tb/dbg_trig_unit_bench.sv
`timescale 1ns/1ps
module dbg_trig_unit_bench;

  localparam int AW = 16;
  localparam int PW = 8;
  localparam logic [AW-1:0] ADR_A = 16'h1234;
  localparam logic [AW-1:0] ADR_B = 16'h2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 0, bus_rd = 0, bus_fetch = 0, exec_valid = 0, pipe_flush = 0;
  logic [AW-1:0] bus_addr = '0, cmp_addr_a = '0, cmp_addr_b = '0, cmp_addr_c = '0;
  logic [PW-1:0] bus_page = '0, cmp_page_a = '0, cmp_page_b = '0, cmp_page_c = '0;
  logic [1:0] page_sel = 2'd0, trig_mode = 2'd0;
  logic dir_en_a = 0, dir_rd_a = 0, dir_en_b = 0, dir_rd_b = 0;
  logic tag_sel = 0, brk_en = 0, arm = 0;
  logic match_a, match_b, match_c, trig, brk_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_trig_unit #(.AW(AW), .PW(PW), .QDEPTH(4)) u_dbg_trig_unit (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_page(bus_page), .bus_rd(bus_rd), .bus_fetch(bus_fetch),
    .exec_valid(exec_valid), .pipe_flush(pipe_flush),
    .cmp_addr_a(cmp_addr_a), .cmp_addr_b(cmp_addr_b), .cmp_addr_c(cmp_addr_c),
    .cmp_page_a(cmp_page_a), .cmp_page_b(cmp_page_b), .cmp_page_c(cmp_page_c),
    .page_sel(page_sel), .dir_en_a(dir_en_a), .dir_rd_a(dir_rd_a),
    .dir_en_b(dir_en_b), .dir_rd_b(dir_rd_b), .tag_sel(tag_sel),
    .trig_mode(trig_mode), .brk_en(brk_en), .arm(arm),
    .match_a(match_a), .match_b(match_b), .match_c(match_c),
    .trig(trig), .brk_req(brk_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change 1 ns after an edge; registered outputs are read there too.
  task automatic step();
    @(posedge clk);
    #1;
    bus_valid = 0; bus_fetch = 0; exec_valid = 0; pipe_flush = 0; arm = 0;
  endtask

  task automatic bus(input logic [AW-1:0] a, input logic rd, input logic f);
    bus_valid = 1; bus_addr = a; bus_rd = rd; bus_fetch = f;
    step();
  endtask

  task automatic do_exec();
    exec_valid = 1;
    step();
  endtask

  task automatic do_arm();
    arm = 1;
    step();
  endtask

  task automatic do_reset();
    rst = 1;
    step();
    step();
    rst = 0;
  endtask

  initial begin
    step();
    step();
    rst = 0;
    // R11: reset state
    chk("R11 match_a", match_a, 1'b0);
    chk("R11 match_b", match_b, 1'b0);
    chk("R11 match_c", match_c, 1'b0);
    chk("R11 trig", trig, 1'b0);
    chk("R11 brk_req", brk_req, 1'b0);

    // R1 R2 R3 R6 R7: direction sweep, unarmed
    cmp_addr_a = ADR_A; cmp_addr_b = ADR_A; cmp_addr_c = 16'h7777;
    for (int m = 0; m < 4; m++)
      for (int ts = 0; ts < 2; ts++)
        for (int ea = 0; ea < 2; ea++)
          for (int ra = 0; ra < 2; ra++)
            for (int eb = 0; eb < 2; eb++)
              for (int rb = 0; rb < 2; rb++)
                for (int rd = 0; rd < 2; rd++)
                  for (int eq = 0; eq < 2; eq++) begin
                    logic qa, qb, full;
                    string ta, tb;
                    trig_mode = m[1:0]; tag_sel = ts[0];
                    dir_en_a = ea[0]; dir_rd_a = ra[0];
                    dir_en_b = eb[0]; dir_rd_b = rb[0];
                    bus(eq[0] ? ADR_A : ADR_A + 16'd1, rd[0], 1'b0);
                    full = m[1];
                    qa = ts[0] ? 1'b1 : (!ea[0] || (ra[0] == rd[0]));
                    qb = ts[0] ? 1'b1 : full ? qa : (!eb[0] || (rb[0] == rd[0]));
                    ta = ts[0] ? "R6 a" : !ea[0] ? "R1 a" : ra[0] ? "R3 a" : "R2 a";
                    tb = ts[0] ? "R6 b" : full ? "R7 b" : !eb[0] ? "R1 b" : rb[0] ? "R3 b" : "R2 b";
                    chk(ta, match_a, eq[0] & qa);
                    chk(tb, match_b, eq[0] & qb);
                  end

    // R4: page comparison sweep
    tag_sel = 0; dir_en_a = 0; dir_en_b = 0; trig_mode = 2'd1;
    cmp_page_a = 8'h5A;
    for (int ps = 0; ps < 4; ps++)
      for (int pe = 0; pe < 2; pe++) begin
        page_sel = ps[1:0];
        bus_page = pe[0] ? 8'h5A : 8'hA5;
        bus(ADR_A, 1'b1, 1'b0);
        chk("R4 page", match_a, (ps != 1) || pe[0]);
      end
    page_sel = 2'd0;

    // R5, R8 mode 0: force-type trigger and arming
    do_reset();
    cmp_addr_a = ADR_A; cmp_addr_b = ADR_B; trig_mode = 2'd0;
    bus(ADR_A, 1'b1, 1'b0);
    chk("R5 unarmed", trig, 1'b0);
    chk("R5 match seen", match_a, 1'b1);
    do_arm();
    bus(ADR_A, 1'b1, 1'b0);
    chk("R5 fire", trig, 1'b1);
    bus(ADR_A, 1'b1, 1'b0);
    chk("R5 disarmed", trig, 1'b0);
    do_arm();
    step();
    chk("R5 idle", trig, 1'b0);
    bus(ADR_B, 1'b0, 1'b0);
    chk("R8 any B", trig, 1'b1);

    // R8 mode 1
    do_reset(); trig_mode = 2'd1;
    do_arm();
    bus(ADR_B, 1'b0, 1'b0);
    chk("R8 A only, B ignored", trig, 1'b0);
    bus(ADR_A, 1'b0, 1'b0);
    chk("R8 A only, A fires", trig, 1'b1);

    // R8 mode 2
    do_reset(); trig_mode = 2'd2;
    do_arm();
    bus(ADR_B, 1'b0, 1'b0);
    chk("R8 B before A", trig, 1'b0);
    bus(ADR_A, 1'b0, 1'b0);
    chk("R8 A arms sequence", trig, 1'b0);
    bus(ADR_B, 1'b0, 1'b0);
    chk("R8 B after A", trig, 1'b1);

    // R8 mode 3
    do_reset(); trig_mode = 2'd3; cmp_addr_b = ADR_A;
    do_arm();
    bus(ADR_A, 1'b0, 1'b0);
    chk("R8 A with B", trig, 1'b0);
    cmp_addr_b = ADR_B;
    bus(ADR_A, 1'b0, 1'b0);
    chk("R8 A without B", trig, 1'b1);

    // R6: tagged trigger, direction bits ignored, fetch order
    do_reset(); tag_sel = 1; trig_mode = 2'd1; dir_en_a = 1; dir_rd_a = 1;
    do_arm();
    bus(ADR_A, 1'b0, 1'b1);
    chk("R6 tag only", trig, 1'b0);
    chk("R6 write matches", match_a, 1'b1);
    bus(16'h3000, 1'b1, 1'b1);
    chk("R6 no fire", trig, 1'b0);
    bus(16'h3002, 1'b1, 1'b1);
    do_exec();
    chk("R6 exec fires", trig, 1'b1);
    do_exec();
    chk("R6 untagged exec", trig, 1'b0);
    do_exec();
    chk("R6 untagged exec 2", trig, 1'b0);

    // R10: flush drops tags
    do_arm();
    bus(ADR_A, 1'b1, 1'b1);
    pipe_flush = 1;
    step();
    do_exec();
    chk("R10 flushed tag", trig, 1'b0);
    bus(16'h3000, 1'b1, 1'b1);
    do_exec();
    chk("R10 clean queue", trig, 1'b0);
    bus(ADR_A, 1'b1, 1'b1);
    do_exec();
    chk("R10 still armed", trig, 1'b1);

    // R9: breakpoint C precedence
    do_reset(); tag_sel = 1; trig_mode = 2'd1; dir_en_a = 0;
    cmp_addr_c = ADR_A; brk_en = 1;
    do_arm();
    bus(ADR_A, 1'b1, 1'b1);
    chk("R9 no early brk", brk_req, 1'b0);
    do_exec();
    chk("R9 brk", brk_req, 1'b1);
    chk("R9 trig suppressed", trig, 1'b0);
    brk_en = 0;
    bus(ADR_A, 1'b1, 1'b1);
    do_exec();
    chk("R9 brk disabled", brk_req, 1'b0);
    chk("R9 armed kept", trig, 1'b1);

    // R9 with force-type A/B
    do_reset(); tag_sel = 0; brk_en = 1; cmp_addr_c = 16'h4000;
    bus(16'h4000, 1'b1, 1'b1);
    chk("R9 match_c", match_c, 1'b1);
    chk("R9 brk waits", brk_req, 1'b0);
    do_exec();
    chk("R9 brk on exec", brk_req, 1'b1);

    // R11: reset mid-flight
    bus(16'h4000, 1'b1, 1'b1);
    do_reset();
    do_exec();
    chk("R11 queue cleared", brk_req, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule